// File: doc/BRIEF.md
# Prescaled Timer With Compare-Driven Counter Reset

This block is a free-running up-counter that advances once per prescaled tick of the bus clock. A set of compare channels watches the counter. When the count reaches a channel's programmed value, that channel raises a flag and drives its output-compare pin according to a programmed action. The last channel can also serve as the period register. When reset-on-compare is enabled, the counter returns to zero after it reaches that channel's value.

The period under reset-on-compare is exact. The counter visits every value from zero up to the top value. Every value below the top lasts one full prescaled tick. The top value lasts exactly one bus cycle, after which the counter and the prescaler phase restart together. The period is therefore the top value times the division ratio, plus one bus cycle. Output-compare waveforms derived from the counter inherit this period.

A simple synchronous register port sets the enables, the division ratio, the per-channel actions and the compare values. The same port reads and clears the event flags and loads the counter.

Top module: `cmp_reset_timer`

## Requirements
- R1: After synchronous reset, the count, all output-compare pins, all flags and all registers are zero.
- R2: When the run bit (CTRL bit 0) is set and CTRL[4:2] holds k, the counter advances by one every 2^k bus cycles, for k from 0 to 7.
- R3: When reset-on-compare (CTRL bit 1) is clear, the counter wraps from 0xFFFF to 0 and sets the overflow flag (FLAG bit 8) on that wrap.
- R4: When reset-on-compare is set and the top compare value (channel 7) is nonzero, the counter counts 0 up to the top value. The top value is held for exactly one bus cycle, then the count is 0. The period is top × 2^k + 1 bus cycles.
- R5: When reset-on-compare is set and the top compare value is 0, the count stays at 0.
- R6: In the first bus cycle in which the count equals compare value i, flag bit i is set and the output action in ACT[2i+1:2i] is applied in the following cycle. The action codes are 00 none, 01 toggle, 10 clear, 11 set.
- R7: Writing a 1 to a FLAG bit clears it. A new event in the same cycle takes precedence over the clear.
- R8: While the run bit is clear, the count does not change and the prescaler phase is held at its start.
- R9: Writing COUNT loads the written value into the counter in the next cycle and restarts the prescaler phase.
- R10: The register addresses are CTRL 0, FLAG 1, COUNT 2, ACT 3, and compare channel i at 8+i. Reads return the current contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| count_o | output | 16 | Current counter value |
| oc_o | output | 8 | Output-compare pins |
| cmp_flag_o | output | 8 | Per-channel compare flags |
| ovf_flag_o | output | 1 | Counter overflow flag |

## Verification
The assertions check the following on every cycle:
- The count reaches 0 on the cycle after it sits at a nonzero top value, and stays held at zero when the top value is zero.
- The count is frozen while the timer is stopped or between ticks.
- Each compare hit moves its pin as its action code dictates, and a pin stays still without a hit.
- Each overflow event lands in the flag.

Only the bench scenarios can show that the whole period is top × 2^k + 1 cycles, that every division ratio is correct, and that flag clearing and counter loads interact correctly with live events. The bench covers these through a lockstep reference model and a direct period measurement.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    typedef struct packed {
        logic [2:0] prs;
        logic       crst;
        logic       run;
    } ctrl_t;

    localparam logic [3:0] ADR_CTRL  = 4'd0;
    localparam logic [3:0] ADR_FLAG  = 4'd1;
    localparam logic [3:0] ADR_COUNT = 4'd2;
    localparam logic [3:0] ADR_ACT   = 4'd3;
    localparam logic [3:0] ADR_CMP0  = 4'd8;

    function automatic logic oc_next(oc_act_e a, logic cur);
        case (a)
            ACT_TOGGLE: return ~cur;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/cmpt_prescaler.sv
module cmpt_prescaler #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           restart,
    input  logic [PSW-1:0] prs,
    output logic           tick,
    output logic           fresh
);
    localparam int PCW = (1 << PSW) - 1;

    logic [PCW-1:0] pcnt;
    logic [PCW-1:0] div_m1;

    always_comb begin
        div_m1 = PCW'((32'd1 << prs) - 32'd1);
        tick   = run && (pcnt >= div_m1);
        fresh  = run && (pcnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R8: a stopped timer keeps its phase at the start
    p_phase_held_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pcnt == '0));

endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         crst,
    input  logic [W-1:0] top,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         restart,
    output logic         ovf_evt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic at_top;
    logic hold_zero;

    always_comb begin
        at_top    = run && crst && (top != '0) && (cnt == top);
        hold_zero = run && crst && (top == '0);
        restart   = at_top || load;
        ovf_evt   = tick && !crst && !load && (cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (at_top || hold_zero) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the top value lasts one bus cycle only
    p_top_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (run && crst && top != '0 && cnt == top && !load) |=> (cnt == '0));

    // R5: zero top value pins the count at zero
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (run && crst && top == '0 && !load) |=> (cnt == '0));

    // R9: a load lands in the next cycle
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/cmpt_channel.sv
module cmpt_channel
    import cmpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fresh,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  oc_act_e      act,
    output logic         hit,
    output logic         oc_q
);
    assign hit = fresh && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q <= 1'b0;
        end else if (hit) begin
            oc_q <= oc_next(act, oc_q);
        end
    end

    // R6: pin reacts to a hit per its action code
    p_set_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_SET) |=> oc_q);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_CLEAR) |=> !oc_q);
    p_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && act == ACT_TOGGLE) |=> (oc_q != $past(oc_q)));
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!hit || act == ACT_NONE) |=> $stable(oc_q));

endmodule

// File: rtl/cmp_reset_timer.sv
module cmp_reset_timer
    import cmpt_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 8,
    parameter int AW  = 4,
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    output logic [W-1:0]   count_o,
    output logic [NCH-1:0] oc_o,
    output logic [NCH-1:0] cmp_flag_o,
    output logic           ovf_flag_o
);
    localparam int TOPCH = NCH - 1;
    localparam int ACTW  = 2 * NCH;
    localparam int CTW   = $bits(ctrl_t);

    ctrl_t           ctrl_q;
    logic [ACTW-1:0] act_q;
    logic [W-1:0]    cmp_q [NCH];
    logic [NCH:0]    flag_q;

    logic            tick, fresh, restart, ovf_evt, load;
    logic [W-1:0]    cnt;
    logic [NCH-1:0]  hit;
    logic [NCH:0]    flag_clr;
    logic [NCH:0]    flag_set;

    always_comb begin
        load     = bus_wr && (bus_addr == ADR_COUNT);
        flag_clr = (bus_wr && bus_addr == ADR_FLAG) ? bus_wdata[NCH:0] : '0;
        flag_set = {ovf_evt, hit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            act_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == ADR_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTW-1:0]);
            if (bus_wr && bus_addr == ADR_ACT)  act_q  <= bus_wdata[ACTW-1:0];
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[i] <= '0;
            end else if (bus_wr && bus_addr == AW'(ADR_CMP0 + i)) begin
                cmp_q[i] <= bus_wdata;
            end
        end
    end

    cmpt_prescaler #(.PSW(PSW)) u_prs (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (restart),
        .prs     (ctrl_q.prs),
        .tick    (tick),
        .fresh   (fresh)
    );

    cmpt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .tick     (tick),
        .crst     (ctrl_q.crst),
        .top      (cmp_q[TOPCH]),
        .load     (load),
        .load_val (bus_wdata),
        .cnt      (cnt),
        .restart  (restart),
        .ovf_evt  (ovf_evt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        cmpt_channel #(.W(W)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .fresh (fresh),
            .cnt   (cnt),
            .cmp   (cmp_q[i]),
            .act   (oc_act_e'(act_q[2*i +: 2])),
            .hit   (hit[i]),
            .oc_q  (oc_o[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL) begin
            bus_rdata = W'(ctrl_q);
        end else if (bus_addr == ADR_FLAG) begin
            bus_rdata = W'(flag_q);
        end else if (bus_addr == ADR_COUNT) begin
            bus_rdata = cnt;
        end else if (bus_addr == ADR_ACT) begin
            bus_rdata = W'(act_q);
        end else if (bus_addr >= ADR_CMP0 && (int'(bus_addr) - int'(ADR_CMP0)) < NCH) begin
            bus_rdata = cmp_q[int'(bus_addr) - int'(ADR_CMP0)];
        end
    end

    assign count_o    = cnt;
    assign cmp_flag_o = flag_q[NCH-1:0];
    assign ovf_flag_o = flag_q[NCH];

    // R3: a wrap event always reaches the overflow flag
    p_ovf_flag_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> flag_q[NCH]);

    // R8: a stopped timer keeps its count
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !load) |=> $stable(cnt));

    // R2: between ticks the count does not move
    p_no_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !ctrl_q.crst && !tick && !load) |=> $stable(cnt));

    // R7: an event wins over a simultaneous clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> flag_q[0]);

endmodule

// File: tb/tb_cmp_reset_timer.sv
module tb_cmp_reset_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, count_o;
    logic [7:0]  oc_o, cmp_flag_o;
    logic        ovf_flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit lockstep = 1'b0;

    // reference model state
    int m_cnt, m_pc, m_ctrl, m_act, m_flags, m_oc;
    int m_cmp [8];

    always #2 clk = ~clk;

    cmp_reset_timer dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_o(count_o),
        .oc_o(oc_o), .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural model, one step per bus clock
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_pc = 0; m_ctrl = 0; m_act = 0; m_flags = 0; m_oc = 0;
            foreach (m_cmp[i]) m_cmp[i] = 0;
        end else begin
            int run, crst, divn, top, setv, clrv, ncnt, npc, noc;
            bit fr, tk;
            run  = m_ctrl & 1;
            crst = (m_ctrl >> 1) & 1;
            divn = 1 << ((m_ctrl >> 2) & 7);
            top  = m_cmp[7];
            fr   = run && (m_pc == 0);
            tk   = run && (m_pc >= divn - 1);
            setv = 0;
            noc  = m_oc;
            for (int i = 0; i < 8; i++) begin
                if (fr && m_cnt == m_cmp[i]) begin
                    int a;
                    a = (m_act >> (2 * i)) & 3;
                    setv |= (1 << i);
                    if (a == 1) noc ^= (1 << i);
                    else if (a == 2) noc &= ~(1 << i);
                    else if (a == 3) noc |= (1 << i);
                end
            end
            ncnt = m_cnt;
            npc  = tk ? 0 : m_pc + 1;
            if (!run) npc = 0;
            if (bus_wr && bus_addr == 2) begin
                ncnt = bus_wdata; npc = 0;
            end else if (run && crst && top != 0 && m_cnt == top) begin
                ncnt = 0; npc = 0;
            end else if (run && crst && top == 0) begin
                ncnt = 0;
            end else if (tk) begin
                if (!crst && m_cnt == 16'hFFFF) setv |= (1 << 8);
                ncnt = (m_cnt + 1) & 16'hFFFF;
            end
            clrv = (bus_wr && bus_addr == 1) ? (bus_wdata & 9'h1FF) : 0;
            m_flags = (m_flags & ~clrv) | setv;
            m_cnt = ncnt; m_pc = npc; m_oc = noc;
            if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata & 5'h1F;
            if (bus_wr && bus_addr == 3) m_act = bus_wdata;
            if (bus_wr && bus_addr >= 8) m_cmp[bus_addr - 8] = bus_wdata;
        end
    end

    // lockstep comparison away from the active edge
    always @(negedge clk) begin
        if (lockstep && !rst) begin
            check(count_o == m_cnt[15:0], "R2 R3 R4 R5 count", count_o, m_cnt);
            check(oc_o == m_oc[7:0], "R6 pins", oc_o, m_oc);
            check({ovf_flag_o, cmp_flag_o} == m_flags[8:0], "R3 R6 R7 flags",
                  {ovf_flag_o, cmp_flag_o}, m_flags);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(count_o == 0, "R1 count", count_o, 0);
        check(oc_o == 0 && cmp_flag_o == 0 && !ovf_flag_o, "R1 outputs", oc_o, 0);
        bus_addr = 4'd0; #0;
        check(bus_rdata == 0, "R1 ctrl", bus_rdata, 0);
        lockstep = 1'b1;

        // R6 actions on a free-running count, divide by 1
        wr(4'd8, 16'd3);
        wr(4'd9, 16'd10);
        wr(4'd10, 16'd20);
        wr(4'd11, 16'd20);
        wr(4'd3, 16'b11_10_11_01);
        wr(4'd0, 16'b000_0_1);
        idle(80);

        // R10 register readback
        bus_addr = 4'd3; #1;
        check(bus_rdata == 16'b11_10_11_01, "R10 ACT read", bus_rdata, 16'b11_10_11_01);
        bus_addr = 4'd9; #1;
        check(bus_rdata == 16'd10, "R10 compare read", bus_rdata, 10);

        // R2 divide by 4 and by 128
        wr(4'd2, 16'd0);
        wr(4'd0, 16'b010_0_1);
        idle(60);
        wr(4'd0, 16'b111_0_1);
        idle(400);

        // R4 reset on compare: top 5, divide by 4 -> period 21
        wr(4'd15, 16'd5);
        wr(4'd2, 16'd0);
        wr(4'd0, 16'b010_1_1);
        while (count_o != 16'd5) @(negedge clk);
        @(negedge clk);
        check(count_o == 0, "R4 top lasts one cycle", count_o, 0);
        begin
            int per = 1;
            while (count_o != 16'd5) begin @(negedge clk); per++; end
            check(per == 21, "R4 period", per, 21);
        end
        idle(100);
        // R4 divide by 1: period top+1
        wr(4'd0, 16'b000_1_1);
        idle(40);

        // R5 zero top holds at zero
        wr(4'd15, 16'd0);
        idle(30);
        check(count_o == 0, "R5 held", count_o, 0);

        // R9 load, R3 wrap and overflow flag
        wr(4'd0, 16'b000_0_1);
        wr(4'd2, 16'hFFF0);
        check(count_o == 16'hFFF1 || count_o == 16'hFFF0, "R9 load", count_o, 16'hFFF0);
        idle(30);
        check(ovf_flag_o == 1'b1, "R3 overflow flag", ovf_flag_o, 1);

        // R7 write-1-to-clear
        wr(4'd1, 16'h1FF);
        check(ovf_flag_o == 1'b0, "R7 clear overflow", ovf_flag_o, 0);
        idle(20);

        // R8 stopped counter freezes
        wr(4'd0, 16'b000_0_0);
        begin
            logic [15:0] held;
            held = count_o;
            idle(25);
            check(count_o == held, "R8 frozen", count_o, held);
        end
        wr(4'd0, 16'b001_0_1);
        idle(50);

        lockstep = 1'b0;
        finish_run();
    end
endmodule